// File: doc/BRIEF.md
# Interrupt Entry and Reset Sequencer

This block sits beside a small 8-bit processor core and takes over at instruction boundaries whenever an interrupt is pending. Each interrupt source sets or clears its own bit in a pending mask. When the core strobes a boundary while any bit is set, the sequencer picks a winner. The non-maskable source wins over the maskable sources. A maskable request is honoured only if the interrupt-disable flag, as it stood before the instruction that just finished, is clear. A jammed core takes neither kind.

A taken interrupt saves the return address and the status byte on the stack in page one, one byte at a time over a request/acknowledge memory handshake. It then fetches the two-byte vector and hands the core the new program counter, the new stack pointer, the new status byte and a seven-cycle charge. The same engine fetches the reset vector. It does so by itself after power-on and again whenever a warm reset strobe arrives while it is idle.

Source bit 0 is the non-maskable source and bit 1 is a one-shot maskable source. Bits 2 and up are level maskable sources, which stay pending until their own clear strobe.

Top module: `irq_seq`

## Requirements
- R1: A `src_set` bit sets the matching pending bit and a `src_clr` bit clears it. When both hit the same bit in the same cycle, set wins. The mask is evaluated only on a `boundary` cycle while idle.
- R2: When bit 0 and any maskable bit are pending at a boundary, the entry uses the non-maskable vector.
- R3: A maskable-only entry is taken only when `irq_mask_pre` is 0. The current status byte has no effect on that choice. No entry of either kind is taken while `jammed` is 1.
- R4: An entry writes three bytes, in order: PC[15:8], PC[7:0], and the current status with bit 4 cleared and bit 5 set. Each byte goes to address 0x0100 + S, and S then drops by one modulo 256. `sp_new` is the final S.
- R5: A non-maskable entry reads 0xFFFA (low byte) and then 0xFFFB (high byte), and gives `status_new` = status with bit 4 cleared. A maskable entry reads 0xFFFE and then 0xFFFF, and also sets bit 2 of `status_new`.
- R6: Each entry ends with a one-cycle `done` pulse that carries `cyc_charge` = 7. `cyc_total` grows by 7 per entry.
- R7: Every boundary evaluation with a nonzero mask clears bits 0 and 1, whether or not an entry is taken. Bits 2 and up stay set.
- R8: A reset sequence reads 0xFFFC and then 0xFFFD. It ends with `done`, `jam_clear` = 1, `status_new` = 0x04 and `cyc_charge` = 0. `sp_new` is 0 after power-on and `sp_cur` after a warm reset.
- R9: Power-on reset clears the pending mask and `cyc_total`, and the reset sequence then starts by itself.
- R10: `mem_req` stays high with a stable address, direction and write data until `mem_ack`. Each acknowledge completes exactly one access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| src_set | input | NSRC | Per-source pending set strobes |
| src_clr | input | NSRC | Per-source pending clear strobes |
| boundary | input | 1 | Instruction boundary strobe |
| warm_rst | input | 1 | Start a reset sequence (taken when idle) |
| jammed | input | 1 | Core is jammed |
| irq_mask_pre | input | 1 | Interrupt-disable flag before the last instruction |
| status_now | input | 8 | Current status byte |
| pc_cur | input | 16 | Return address to save |
| sp_cur | input | 8 | Current stack pointer |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 16 | Access address |
| mem_wdata | output | 8 | Write data |
| mem_ack | input | 1 | Access complete |
| mem_rdata | input | 8 | Read data, valid with mem_ack |
| done | output | 1 | New PC/SP/status valid this cycle |
| pc_new | output | 16 | Loaded program counter |
| sp_new | output | 8 | Stack pointer after the sequence |
| status_new | output | 8 | Status byte after the sequence |
| cyc_charge | output | 4 | Cycles charged with done |
| cyc_total | output | CYC_W | Accumulated entry cycles |
| jam_clear | output | 1 | Clear the jammed flag (reset done) |
| busy | output | 1 | Sequence in progress |

## Verification
The bench pends the non-maskable source together with a level source. A design with the priority inverted would fetch 0xFFFE first, and one that dropped level bits would never make the follow-up maskable entry. It supplies the two status inputs with opposite disable flags. This exposes a design that masks on the current byte: it takes an entry that should be refused, or refuses one that should be taken. It also checks that a refused one-shot request and an NMI seen while jammed are discarded rather than kept, since a design that held them would enter later. A stack pointer of 0x01 checks the wrap to 0x01FF, and a simultaneous set and clear checks that set wins.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

  typedef enum logic [2:0] {
    S_BOOT, S_IDLE, S_PCH, S_PCL, S_PST, S_VLO, S_VHI, S_FIN
  } seq_state_t;

  typedef enum logic [1:0] {
    K_RST, K_NMI, K_IRQ
  } entry_kind_t;

  localparam int NMI_BIT     = 0;
  localparam int ONESHOT_BIT = 1;

  localparam logic [7:0]  FLAG_I       = 8'h04;
  localparam logic [7:0]  FLAG_B       = 8'h10;
  localparam logic [7:0]  FLAG_U       = 8'h20;
  localparam logic [7:0]  RESET_STATUS = FLAG_I;
  localparam logic [7:0]  STACK_PAGE   = 8'h01;
  localparam logic [15:0] VEC_NMI      = 16'hFFFA;
  localparam logic [15:0] VEC_RST      = 16'hFFFC;
  localparam logic [15:0] VEC_IRQ      = 16'hFFFE;

endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/irq_pend_mask.sv
module irq_pend_mask
  import irq_seq_pkg::*;
#(
  parameter int NSRC = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] set_i,
  input  logic [NSRC-1:0] clr_i,
  input  logic            svc_i,
  output logic [NSRC-1:0] pend_o
);
  localparam logic [NSRC-1:0] DROP_MASK =
    NSRC'((1 << NMI_BIT) | (1 << ONESHOT_BIT));

  logic [NSRC-1:0] pend_q, pend_d;

  always_comb begin
    pend_d = pend_q & ~clr_i;
    if (svc_i) pend_d = pend_d & ~DROP_MASK;
    pend_d = pend_d | set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irq_seq.sv
module irq_seq
  import irq_seq_pkg::*;
#(
  parameter int NSRC      = 4,
  parameter int CYC_W     = 16,
  parameter int ENTRY_CYC = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  src_set,
  input  logic [NSRC-1:0]  src_clr,
  input  logic             boundary,
  input  logic             warm_rst,
  input  logic             jammed,
  input  logic             irq_mask_pre,
  input  logic [7:0]       status_now,
  input  logic [15:0]      pc_cur,
  input  logic [7:0]       sp_cur,
  output logic             mem_req,
  output logic             mem_we,
  output logic [15:0]      mem_addr,
  output logic [7:0]       mem_wdata,
  input  logic             mem_ack,
  input  logic [7:0]       mem_rdata,
  output logic             done,
  output logic [15:0]      pc_new,
  output logic [7:0]       sp_new,
  output logic [7:0]       status_new,
  output logic [3:0]       cyc_charge,
  output logic [CYC_W-1:0] cyc_total,
  output logic             jam_clear,
  output logic             busy
);
  localparam logic [3:0] CHARGE = 4'(ENTRY_CYC);

  logic            rst_i_n;
  logic [NSRC-1:0] pend;
  logic            svc;

  seq_state_t  state_q, state_d;
  entry_kind_t kind_q, kind_d;
  logic [15:0] pc_q, pc_d;
  logic [7:0]  sp_q, sp_d;
  logic [7:0]  st_q, st_d;
  logic [7:0]  vlo_q, vlo_d;
  logic [15:0] pcn_q, pcn_d;
  logic [CYC_W-1:0] cyc_q, cyc_d;
  logic [15:0] vec_base;
  logic        take;

  irq_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_i_n)
  );

  irq_pend_mask #(.NSRC(NSRC)) u_pend (
    .clk   (clk),
    .rst_n (rst_i_n),
    .set_i (src_set),
    .clr_i (src_clr),
    .svc_i (svc),
    .pend_o(pend)
  );

  always_comb begin
    unique case (kind_q)
      K_NMI:   vec_base = VEC_NMI;
      K_IRQ:   vec_base = VEC_IRQ;
      default: vec_base = VEC_RST;
    endcase
  end

  assign take = !jammed && (pend[NMI_BIT] || !irq_mask_pre);

  always_comb begin
    state_d = state_q;
    kind_d  = kind_q;
    pc_d    = pc_q;
    sp_d    = sp_q;
    st_d    = st_q;
    vlo_d   = vlo_q;
    pcn_d   = pcn_q;
    cyc_d   = cyc_q;
    svc     = 1'b0;
    unique case (state_q)
      S_BOOT: state_d = S_VLO;
      S_IDLE: begin
        if (warm_rst) begin
          kind_d  = K_RST;
          sp_d    = sp_cur;
          state_d = S_VLO;
        end else if (boundary && (|pend)) begin
          svc = 1'b1;
          if (take) begin
            kind_d  = pend[NMI_BIT] ? K_NMI : K_IRQ;
            pc_d    = pc_cur;
            sp_d    = sp_cur;
            st_d    = status_now;
            state_d = S_PCH;
          end
        end
      end
      S_PCH, S_PCL, S_PST: begin
        if (mem_ack) begin
          sp_d = sp_q - 8'd1;
          unique case (state_q)
            S_PCH:   state_d = S_PCL;
            S_PCL:   state_d = S_PST;
            default: state_d = S_VLO;
          endcase
        end
      end
      S_VLO: begin
        if (mem_ack) begin
          vlo_d   = mem_rdata;
          state_d = S_VHI;
        end
      end
      S_VHI: begin
        if (mem_ack) begin
          pcn_d   = {mem_rdata, vlo_q};
          state_d = S_FIN;
        end
      end
      default: begin
        if (kind_q != K_RST) cyc_d = cyc_q + CYC_W'(ENTRY_CYC);
        state_d = S_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      state_q <= S_BOOT;
      kind_q  <= K_RST;
      pc_q    <= '0;
      sp_q    <= '0;
      st_q    <= '0;
      vlo_q   <= '0;
      pcn_q   <= '0;
      cyc_q   <= '0;
    end else begin
      state_q <= state_d;
      kind_q  <= kind_d;
      pc_q    <= pc_d;
      sp_q    <= sp_d;
      st_q    <= st_d;
      vlo_q   <= vlo_d;
      pcn_q   <= pcn_d;
      cyc_q   <= cyc_d;
    end
  end

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = vec_base;
    mem_wdata = '0;
    unique case (state_q)
      S_PCH: begin
        mem_req = 1'b1; mem_we = 1'b1;
        mem_addr = {STACK_PAGE, sp_q}; mem_wdata = pc_q[15:8];
      end
      S_PCL: begin
        mem_req = 1'b1; mem_we = 1'b1;
        mem_addr = {STACK_PAGE, sp_q}; mem_wdata = pc_q[7:0];
      end
      S_PST: begin
        mem_req = 1'b1; mem_we = 1'b1;
        mem_addr = {STACK_PAGE, sp_q}; mem_wdata = (st_q & ~FLAG_B) | FLAG_U;
      end
      S_VLO: begin
        mem_req = 1'b1; mem_addr = vec_base;
      end
      S_VHI: begin
        mem_req = 1'b1; mem_addr = vec_base | 16'h0001;
      end
      default: ;
    endcase
  end

  always_comb begin
    unique case (kind_q)
      K_RST:   status_new = RESET_STATUS;
      K_NMI:   status_new = st_q & ~FLAG_B;
      default: status_new = (st_q & ~FLAG_B) | FLAG_I;
    endcase
  end

  assign done       = (state_q == S_FIN);
  assign jam_clear  = done && (kind_q == K_RST);
  assign cyc_charge = (done && kind_q != K_RST) ? CHARGE : 4'd0;
  assign pc_new     = pcn_q;
  assign sp_new     = sp_q;
  assign cyc_total  = cyc_q;
  assign busy       = (state_q != S_IDLE);
endmodule

// File: rtl/irq_seq_chk.sv
module irq_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_req,
  input logic        mem_we,
  input logic [15:0] mem_addr,
  input logic [7:0]  mem_wdata,
  input logic        mem_ack,
  input logic        done,
  input logic        jam_clear,
  input logic [3:0]  cyc_charge,
  input logic [7:0]  status_new
);
  AST_STACK_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (mem_addr[15:8] == 8'h01)); // R4

  AST_VECTOR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |-> (mem_addr[15:3] == 13'h1FFF)); // R5

  AST_ENTRY_NO_BREAK: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !jam_clear) |-> (status_new[4] == 1'b0)); // R5

  AST_ENTRY_CHARGE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !jam_clear) |-> (cyc_charge == 4'd7)); // R6

  AST_RESET_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    jam_clear |-> (status_new == 8'h04 && cyc_charge == 4'd0)); // R8

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                               && $stable(mem_wdata))); // R10

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_req); // R10
endmodule

bind irq_seq irq_seq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .mem_ack   (mem_ack),
  .done      (done),
  .jam_clear (jam_clear),
  .cyc_charge(cyc_charge),
  .status_new(status_new)
);

// File: tb/irq_seq_tb.sv
module irq_seq_tb;
  localparam int NSRC  = 4;
  localparam int CYC_W = 16;

  logic clk, rst_n;
  logic [NSRC-1:0] src_set, src_clr;
  logic boundary, warm_rst, jammed, irq_mask_pre;
  logic [7:0] status_now, sp_cur;
  logic [15:0] pc_cur;
  logic mem_req, mem_we, mem_ack;
  logic [15:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;
  logic done, jam_clear, busy;
  logic [15:0] pc_new;
  logic [7:0] sp_new, status_new;
  logic [3:0] cyc_charge;
  logic [CYC_W-1:0] cyc_total;

  irq_seq #(.NSRC(NSRC), .CYC_W(CYC_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .src_set(src_set), .src_clr(src_clr),
    .boundary(boundary), .warm_rst(warm_rst), .jammed(jammed),
    .irq_mask_pre(irq_mask_pre), .status_now(status_now), .pc_cur(pc_cur),
    .sp_cur(sp_cur), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .done(done), .pc_new(pc_new), .sp_new(sp_new), .status_new(status_new),
    .cyc_charge(cyc_charge), .cyc_total(cyc_total), .jam_clear(jam_clear),
    .busy(busy)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct {
    bit          is_done;
    bit          we;
    logic [15:0] addr;
    logic [7:0]  data;
    logic [15:0] pc;
    logic [7:0]  sp;
    logic [7:0]  st;
    logic [3:0]  chg;
    bit          jc;
    string       tag;
  } item_t;

  item_t sbq[$];
  int nchk = 0, nfail = 0, entries = 0, lat = 0, lat_seed = 0, wd = 0;

  function automatic logic [7:0] mem_model(input logic [15:0] a);
    case (a)
      16'hFFFA: return 8'h34;
      16'hFFFB: return 8'h12;
      16'hFFFC: return 8'h00;
      16'hFFFD: return 8'h80;
      16'hFFFE: return 8'hCD;
      16'hFFFF: return 8'hAB;
      default:  return a[7:0] ^ 8'h5A;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic push_mem(input bit we, input logic [15:0] a, input logic [7:0] d,
                          input string tag);
    item_t it;
    it.is_done = 0; it.we = we; it.addr = a; it.data = d;
    it.pc = '0; it.sp = '0; it.st = '0; it.chg = '0; it.jc = 0; it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic push_done(input logic [15:0] pc, input logic [7:0] sp,
                           input logic [7:0] st, input logic [3:0] chg,
                           input bit jc, input string tag);
    item_t it;
    it.is_done = 1; it.we = 0; it.addr = '0; it.data = '0;
    it.pc = pc; it.sp = sp; it.st = st; it.chg = chg; it.jc = jc; it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic exp_entry(input bit nmi, input logic [15:0] pc,
                           input logic [7:0] sp, input logic [7:0] st,
                           input string tag);
    logic [15:0] v;
    logic [7:0] s;
    v = nmi ? 16'hFFFA : 16'hFFFE;
    s = sp;
    push_mem(1, {8'h01, s}, pc[15:8], tag); s = s - 8'd1;
    push_mem(1, {8'h01, s}, pc[7:0], tag);  s = s - 8'd1;
    push_mem(1, {8'h01, s}, (st & 8'hEF) | 8'h20, tag); s = s - 8'd1;
    push_mem(0, v, 8'h00, tag);
    push_mem(0, v + 16'd1, 8'h00, tag);
    push_done({mem_model(v + 16'd1), mem_model(v)}, s,
              nmi ? (st & 8'hEF) : ((st & 8'hEF) | 8'h04), 4'd7, 0, tag);
    entries++;
  endtask

  task automatic exp_reset(input logic [7:0] sp, input string tag);
    push_mem(0, 16'hFFFC, 8'h00, tag);
    push_mem(0, 16'hFFFD, 8'h00, tag);
    push_done(16'h8000, sp, 8'h04, 4'd0, 1, tag);
  endtask

  task automatic pulse_src(input logic [NSRC-1:0] s, input logic [NSRC-1:0] c);
    @(negedge clk);
    src_set = s; src_clr = c;
    @(negedge clk);
    src_set = '0; src_clr = '0;
  endtask

  task automatic do_boundary(input bit mpre, input logic [7:0] now,
                             input logic [15:0] pc, input logic [7:0] sp,
                             input bit jam);
    @(negedge clk);
    boundary = 1; irq_mask_pre = mpre; status_now = now; pc_cur = pc;
    sp_cur = sp; jammed = jam;
    @(negedge clk);
    boundary = 0; jammed = 0;
  endtask

  task automatic settle(input string tag);
    repeat (60) @(negedge clk);
    chk(sbq.size() == 0, tag, sbq.size(), 0);
    chk(busy == 1'b0, tag, busy, 0);
  endtask

  // Monitor and memory responder
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ack = 0;
    end else begin
      if (done) begin
        if (sbq.size() == 0) chk(0, "R6 unexpected done", pc_new, 0);
        else begin
          item_t e;
          e = sbq.pop_front();
          chk(e.is_done, {e.tag, " done order"}, 1, 0);
          chk(pc_new == e.pc, {e.tag, " pc_new"}, pc_new, e.pc);
          chk(sp_new == e.sp, {e.tag, " sp_new"}, sp_new, e.sp);
          chk(status_new == e.st, {e.tag, " status_new"}, status_new, e.st);
          chk(cyc_charge == e.chg, {e.tag, " cyc_charge R6"}, cyc_charge, e.chg);
          chk(jam_clear == e.jc, {e.tag, " jam_clear R8"}, jam_clear, e.jc);
        end
      end
      if (mem_ack) mem_ack = 0;
      else if (mem_req) begin
        if (lat > 0) lat--;
        else begin
          if (sbq.size() == 0) chk(0, "R10 unexpected access", mem_addr, 0);
          else begin
            item_t e;
            e = sbq.pop_front();
            chk(!e.is_done && (e.we == mem_we) && (e.addr == mem_addr),
                {e.tag, " access addr/dir"}, {15'd0, mem_we, mem_addr},
                {15'd0, e.we, e.addr});
            if (e.we)
              chk(mem_wdata == e.data, {e.tag, " write data"}, mem_wdata, e.data);
          end
          mem_rdata = mem_model(mem_addr);
          mem_ack = 1;
          lat = lat_seed % 3;
          lat_seed++;
        end
      end
    end
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 100000) begin
      nfail++; nchk++;
      $display("FAIL watchdog actual=%0d expected=done", wd);
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    rst_n = 0; src_set = '0; src_clr = '0; boundary = 0; warm_rst = 0;
    jammed = 0; irq_mask_pre = 0; status_now = '0; pc_cur = '0; sp_cur = '0;
    mem_ack = 0; mem_rdata = '0;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(mem_req == 0, "R9 reset mem_req", mem_req, 0);
    chk(done == 0, "R9 reset done", done, 0);
    chk(cyc_total == 0, "R9 reset cyc_total", cyc_total, 0);
    exp_reset(8'h00, "R8 R9 power-on reset");
    rst_n = 1;
    settle("R9 boot settle");

    // R2: NMI wins over level source 2
    pulse_src(4'b0101, 4'b0000);
    exp_entry(1, 16'hC123, 8'hFD, 8'h30, "R2 R4 R5 nmi priority");
    do_boundary(0, 8'h30, 16'hC123, 8'hFD, 0);
    settle("R2 settle");

    // R7: level bit 2 still pending -> IRQ entry
    exp_entry(0, 16'h4567, 8'hFA, 8'h81, "R7 R5 level irq retained");
    do_boundary(0, 8'h81, 16'h4567, 8'hFA, 0);
    settle("R7 settle");

    // R3: masking follows the pre-instruction flag, not status_now
    do_boundary(1, 8'h00, 16'h1111, 8'hF0, 0);
    settle("R3 masked by pre flag");
    exp_entry(0, 16'h2222, 8'hF0, 8'h04, "R3 taken with pre flag clear");
    do_boundary(0, 8'h04, 16'h2222, 8'hF0, 0);
    settle("R3 settle");
    pulse_src(4'b0000, 4'b0100);

    // R7: refused one-shot request is discarded
    pulse_src(4'b0010, 4'b0000);
    do_boundary(1, 8'h00, 16'h3333, 8'hF0, 0);
    settle("R7 one-shot refused");
    do_boundary(0, 8'h00, 16'h3333, 8'hF0, 0);
    settle("R7 one-shot dropped");

    // R3: jammed core takes nothing; NMI dropped, level bit kept
    pulse_src(4'b1001, 4'b0000);
    do_boundary(0, 8'h00, 16'h0200, 8'h80, 1);
    settle("R3 jammed ignored");
    exp_entry(0, 16'h0200, 8'h80, 8'h00, "R7 nmi dropped after jam");
    do_boundary(0, 8'h00, 16'h0200, 8'h80, 0);
    settle("R7 jam settle");
    pulse_src(4'b0000, 4'b1000);

    // R4: stack wrap
    pulse_src(4'b0010, 4'b0000);
    exp_entry(0, 16'hBEEF, 8'h01, 8'hFF, "R4 stack wrap");
    do_boundary(0, 8'hFF, 16'hBEEF, 8'h01, 0);
    settle("R4 settle");
    do_boundary(0, 8'h00, 16'h4444, 8'hF0, 0);
    settle("R7 one-shot cleared after service");

    // R1: set wins over clear in the same cycle
    pulse_src(4'b0100, 4'b0100);
    exp_entry(0, 16'h5555, 8'hE0, 8'h00, "R1 set beats clear");
    do_boundary(0, 8'h00, 16'h5555, 8'hE0, 0);
    settle("R1 settle");
    pulse_src(4'b0000, 4'b0100);
    do_boundary(0, 8'h00, 16'h6666, 8'hE0, 0);
    settle("R1 clear strobe works");

    // R8: warm reset keeps sp_cur
    exp_reset(8'h77, "R8 warm reset");
    @(negedge clk);
    warm_rst = 1; sp_cur = 8'h77;
    @(negedge clk);
    warm_rst = 0;
    settle("R8 settle");

    chk(cyc_total == CYC_W'(entries * 7), "R6 cyc_total", cyc_total, entries * 7);

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule